// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block forms the second ALU operand of a data-processing instruction, together with the carry bit that logical operations would copy into the C flag. It reads the low twelve bits of the instruction word and a select bit. From these it builds either a rotated 8-bit constant or a shifted copy of a register value. The register value can be shifted by a count held in the instruction or by a count held in the low byte of a second register.

The block is purely combinational and sits between the register file read ports and the ALU input. The register file decode chooses which registers drive `rmVal` and `rsVal`. The flag logic supplies the present carry on `carryIn`. The result settles within the same cycle. Several zero-count encodings have special meanings: a shift by the full width, a one-bit rotate through carry, or a plain pass-through. These are resolved inside the block.

Top module: `operand_shifter`

## Requirements
- R1: With `immSel`=1 the operand is `opField[7:0]`, zero-extended, rotated right by twice `opField[11:8]`. The carry is `carryIn` when that count is 0, and otherwise bit 31 of the result.
- R2: With `immSel`=0 and `opField[4]`=0, the count is `opField[11:7]` and the shift kind is `opField[6:5]`, coded 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right.
- R3: An immediate left shift by 0 passes `rmVal` and `carryIn` unchanged. A left shift by 1 to 31 fills the low end with zeros, and the carry is the last bit shifted out.
- R4: An immediate right logical or right arithmetic shift with count field 0 acts as a shift by 32. Logical gives 0, arithmetic gives 32 copies of bit 31, and the carry is bit 31 in both cases.
- R5: An immediate rotate with count field 0 is a one-bit rotate through carry. The operand is `{carryIn, rmVal[31:1]}` and the carry is `rmVal[0]`.
- R6: With `immSel`=0 and `opField[4]`=1, the count is `rsVal[7:0]` and `rsVal[31:8]` has no effect. A count of 0 passes `rmVal` and `carryIn` unchanged.
- R7: A register-count left or right logical shift by exactly 32 gives 0, with carry `rmVal[0]` for a left shift and `rmVal[31]` for a right shift. A count above 32 gives 0 with carry 0.
- R8: A register-count arithmetic shift by 32 or more gives 32 copies of bit 31, with carry bit 31.
- R9: A register-count rotate uses the count modulo 32. A nonzero count that is a multiple of 32 returns `rmVal` with carry `rmVal[31]`.
- R10: For right logical, right arithmetic and rotate with an effective count of 1 to 31, the carry is the last bit shifted out: bit (count-1) of `rmVal`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| immSel | input | 1 | 1 selects the rotated-constant form |
| opField | input | 12 | Low twelve bits of the instruction |
| rmVal | input | 32 | Value of the register to be shifted |
| rsVal | input | 32 | Value of the register holding the shift count |
| carryIn | input | 1 | Present carry flag |
| operand | output | 32 | Second ALU operand |
| carryOut | output | 1 | Shifter carry-out |

## Verification
The cases that are hardest to reach are the register-count counts at and beyond the word width: exactly 32, just above it, and large multiples of 32. A narrow count sweep never produces these, yet they are where the left, right and rotate rules part ways. The register-count sweep therefore runs every count from 0 to 40 and adds 63, 64, 65, 96, 128 and 255. It fills `rsVal[31:8]` with non-zero bits so that any leak of the upper bits into the count shows up. Expected values come from a model that shifts one bit at a time, so the last-bit-out carry follows from counting steps rather than from an indexing formula.

// File: rtl/opshift_pkg.sv
package opshift_pkg;

  localparam int AMT_W = 8;

  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_LSL  = 3'd1,
    OP_LSR  = 3'd2,
    OP_ASR  = 3'd3,
    OP_ROR  = 3'd4,
    OP_RRX  = 3'd5
  } shOp_e;

  typedef struct packed {
    logic             useImm;
    shOp_e            op;
    logic [AMT_W-1:0] amt;
  } shCtrl_t;

endpackage

// File: rtl/opshift_ctrl.sv
module opshift_ctrl
  import opshift_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic             immSel,
  input  logic [11:0]      opField,
  input  logic [AMT_W-1:0] rsLow,
  output shCtrl_t          ctrl
);

  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  logic [1:0] kind;
  logic [4:0] immAmt;
  logic [3:0] rotField;

  assign kind     = opField[6:5];
  assign immAmt   = opField[11:7];
  assign rotField = opField[11:8];

  function automatic shOp_e kindToOp(input logic [1:0] k);
    case (k)
      2'b00:   return OP_LSL;
      2'b01:   return OP_LSR;
      2'b10:   return OP_ASR;
      default: return OP_ROR;
    endcase
  endfunction

  always_comb begin
    ctrl.useImm = 1'b0;
    ctrl.op     = OP_PASS;
    ctrl.amt    = '0;
    if (immSel) begin
      ctrl.useImm = 1'b1;
      ctrl.amt    = AMT_W'({rotField, 1'b0});
      ctrl.op     = (rotField == 4'd0) ? OP_PASS : OP_ROR;
    end else if (opField[4]) begin
      ctrl.amt = rsLow;
      ctrl.op  = (rsLow == '0) ? OP_PASS : kindToOp(kind);
    end else if (immAmt == 5'd0) begin
      case (kind)
        2'b00: ctrl.op = OP_PASS;
        2'b01: begin ctrl.op = OP_LSR; ctrl.amt = FULL; end
        2'b10: begin ctrl.op = OP_ASR; ctrl.amt = FULL; end
        default: begin ctrl.op = OP_RRX; ctrl.amt = AMT_W'(1); end
      endcase
    end else begin
      ctrl.amt = AMT_W'(immAmt);
      ctrl.op  = kindToOp(kind);
    end
  end

  always_comb begin
    if (!$isunknown({immSel, opField, rsLow})) begin
      // R1: constant form only ever rotates, and by an even count
      a_r1_even_rotate: assert (!immSel ||
        (!ctrl.amt[0] && (ctrl.op == OP_PASS || ctrl.op == OP_ROR)))
        else $error("constant form produced odd or non-rotate control");
      // R2/R4: instruction-held counts stay within 1..width once decoded
      a_r2_imm_amount_range: assert (immSel || opField[4] ||
        ctrl.op == OP_PASS || (ctrl.amt != '0 && ctrl.amt <= FULL))
        else $error("instruction-held count out of range");
    end
  end

endmodule

// File: rtl/opshift_datapath.sv
module opshift_datapath
  import opshift_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  shCtrl_t           ctrl,
  input  logic [7:0]        imm8,
  input  logic [DATA_W-1:0] rmVal,
  input  logic              carryIn,
  output logic [DATA_W-1:0] operand,
  output logic              carryOut
);

  localparam int SH_W = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] res;
  logic              cOut;
  logic [DATA_W-1:0] probe;
  logic [SH_W-1:0]   rotAmt;
  logic [SH_W:0]     backAmt;
  logic [AMT_W-1:0]  amtM1;

  assign src     = ctrl.useImm ? DATA_W'(imm8) : rmVal;
  assign rotAmt  = ctrl.amt[SH_W-1:0];
  assign backAmt = (SH_W+1)'(DATA_W) - {1'b0, rotAmt};
  assign amtM1   = ctrl.amt - AMT_W'(1);

  always_comb begin
    res   = src;
    cOut  = carryIn;
    probe = '0;
    case (ctrl.op)
      OP_LSL: begin
        if (ctrl.amt < FULL) begin
          res   = src << ctrl.amt;
          probe = src << amtM1;
          cOut  = probe[DATA_W-1];
        end else if (ctrl.amt == FULL) begin
          res  = '0;
          cOut = src[0];
        end else begin
          res  = '0;
          cOut = 1'b0;
        end
      end
      OP_LSR: begin
        if (ctrl.amt < FULL) begin
          res   = src >> ctrl.amt;
          probe = src >> amtM1;
          cOut  = probe[0];
        end else if (ctrl.amt == FULL) begin
          res  = '0;
          cOut = src[DATA_W-1];
        end else begin
          res  = '0;
          cOut = 1'b0;
        end
      end
      OP_ASR: begin
        if (ctrl.amt < FULL) begin
          res   = DATA_W'($signed(src) >>> ctrl.amt);
          probe = src >> amtM1;
          cOut  = probe[0];
        end else begin
          res  = {DATA_W{src[DATA_W-1]}};
          cOut = src[DATA_W-1];
        end
      end
      OP_ROR: begin
        if (rotAmt == '0) begin
          res  = src;
          cOut = src[DATA_W-1];
        end else begin
          res  = (src >> rotAmt) | (src << backAmt);
          cOut = res[DATA_W-1];
        end
      end
      OP_RRX: begin
        res  = {carryIn, src[DATA_W-1:1]};
        cOut = src[0];
      end
      default: begin
        res  = src;
        cOut = carryIn;
      end
    endcase
  end

  assign operand  = res;
  assign carryOut = cOut;

  always_comb begin
    if (!$isunknown({ctrl, src, carryIn})) begin
      // R3: a left shift never leaves a one in the lowest bit
      a_r3_lsl_zero_fill: assert (ctrl.op != OP_LSL || !operand[0])
        else $error("left shift left a one in bit 0");
      // R4: a right logical shift always clears the top bit
      a_r4_lsr_top_clear: assert (ctrl.op != OP_LSR || !operand[DATA_W-1])
        else $error("right logical shift set the top bit");
      // R8: an arithmetic shift keeps the sign
      a_r8_asr_sign_kept: assert (ctrl.op != OP_ASR ||
        operand[DATA_W-1] == src[DATA_W-1])
        else $error("arithmetic shift lost the sign");
      // R5: one-bit rotate through carry puts the old carry on top
      a_r5_rrx_carry_top: assert (ctrl.op != OP_RRX ||
        operand[DATA_W-1] == carryIn)
        else $error("rotate through carry lost carry-in");
      // R9: a rotate neither creates nor loses ones
      a_r9_ror_ones_kept: assert (ctrl.op != OP_ROR ||
        $countones(operand) == $countones(src))
        else $error("rotate changed the number of ones");
    end
  end

endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import opshift_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              immSel,
  input  logic [11:0]       opField,
  input  logic [DATA_W-1:0] rmVal,
  input  logic [DATA_W-1:0] rsVal,
  input  logic              carryIn,
  output logic [DATA_W-1:0] operand,
  output logic              carryOut
);

  shCtrl_t ctrl;
  logic    unusedRsHigh;

  assign unusedRsHigh = ^rsVal[DATA_W-1:AMT_W];

  opshift_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .immSel  (immSel),
    .opField (opField),
    .rsLow   (rsVal[AMT_W-1:0]),
    .ctrl    (ctrl)
  );

  opshift_datapath #(.DATA_W(DATA_W)) uPath (
    .ctrl     (ctrl),
    .imm8     (opField[7:0]),
    .rmVal    (rmVal),
    .carryIn  (carryIn),
    .operand  (operand),
    .carryOut (carryOut)
  );

endmodule

// File: tb/sim_operand_shifter.sv
module sim_operand_shifter;

  logic        clk = 1'b0;
  logic        immSel = 1'b0;
  logic [11:0] opField = '0;
  logic [31:0] rmVal = '0;
  logic [31:0] rsVal = '0;
  logic        carryIn = 1'b0;
  logic [31:0] operand;
  logic        carryOut;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  operand_shifter u0 (
    .immSel   (immSel),
    .opField  (opField),
    .rmVal    (rmVal),
    .rsVal    (rsVal),
    .carryIn  (carryIn),
    .operand  (operand),
    .carryOut (carryOut)
  );

  function automatic logic [31:0] pattern(input int k);
    case (k)
      0: return 32'h8000_0001;
      1: return 32'h7FFF_FFFE;
      2: return 32'hA5C3_0F96;
      default: return 32'h0000_0000;
    endcase
  endfunction

  // one-bit-at-a-time reference model
  task automatic model(input logic sel, input logic [11:0] f,
                       input logic [31:0] rm, input logic [31:0] rs,
                       input logic cin,
                       output logic [31:0] v, output logic c);
    int n;
    logic [1:0] k;
    c = cin;
    if (sel) begin
      v = {24'b0, f[7:0]};
      n = 2 * int'(f[11:8]);
      for (int i = 0; i < n; i++) begin
        c = v[0];
        v = {v[0], v[31:1]};
      end
      return;
    end
    v = rm;
    k = f[6:5];
    n = f[4] ? int'(rs[7:0]) : int'(f[11:7]);
    if (!f[4] && n == 0) begin
      if (k == 2'b01 || k == 2'b10) n = 32;
      else if (k == 2'b11) begin
        c = v[0];
        v = {cin, v[31:1]};
        return;
      end
    end
    for (int i = 0; i < n; i++) begin
      case (k)
        2'b00: begin c = v[31]; v = v << 1; end
        2'b01: begin c = v[0];  v = v >> 1; end
        2'b10: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
  endtask

  task automatic runCheck(input logic sel, input logic [11:0] f,
                          input logic [31:0] rm, input logic [31:0] rs,
                          input logic cin, input string tag);
    logic [31:0] ev;
    logic        ec;
    @(posedge clk);
    #1;
    immSel = sel; opField = f; rmVal = rm; rsVal = rs; carryIn = cin;
    model(sel, f, rm, rs, cin, ev, ec);
    @(negedge clk);
    checks++;
    if (operand !== ev || carryOut !== ec) begin
      errors++;
      $display("FAIL %s field=%h rm=%h rs=%h cin=%b: got %h/%b expected %h/%b",
               tag, f, rm, rs, cin, operand, carryOut, ev, ec);
    end
  endtask

  initial begin
    logic [7:0] imms [5];
    imms[0] = 8'h00; imms[1] = 8'h01; imms[2] = 8'h80;
    imms[3] = 8'hFF; imms[4] = 8'hA5;

    // all-zero inputs: pass-through of a zero register, carry follows input
    runCheck(1'b0, 12'h000, 32'h0, 32'h0, 1'b1, "R3");

    // R1: every rotate field against several constants and both carries
    for (int r = 0; r < 16; r++)
      for (int m = 0; m < 5; m++)
        for (int c = 0; c < 2; c++)
          runCheck(1'b1, {r[3:0], imms[m]}, pattern(2), 32'hFFFF_FFFF,
                   c[0], "R1");

    // R2: instruction-held counts, all kinds and counts
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 32; a++)
        for (int p = 0; p < 4; p++)
          for (int c = 0; c < 2; c++) begin
            string tag;
            if (a == 0) tag = (k == 0) ? "R2 R3" : (k == 3) ? "R2 R5" : "R2 R4";
            else        tag = (k == 0) ? "R2 R3" : "R2 R10";
            runCheck(1'b0, {a[4:0], k[1:0], 1'b0, 4'h3}, pattern(p),
                     32'h0000_00FF, c[0], tag);
          end

    // register-held counts with junk in the upper bits of the count register
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 47; a++)
        for (int p = 0; p < 4; p++)
          for (int c = 0; c < 2; c++) begin
            int amt;
            string tag;
            case (a)
              41: amt = 63;
              42: amt = 64;
              43: amt = 65;
              44: amt = 96;
              45: amt = 128;
              46: amt = 255;
              default: amt = a;
            endcase
            if (amt == 0) tag = "R6";
            else if (amt >= 32) tag = (k == 2) ? "R8" : (k == 3) ? "R9" : "R7";
            else tag = "R10";
            runCheck(1'b0, {4'h5, 1'b0, k[1:0], 1'b1, 4'h2}, pattern(p),
                     {~pattern(p) ^ 32'h5A5A_5A00, 8'(amt)} >> 0, c[0], tag);
          end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule